// File: doc/BRIEF.md
# Serial Vector Command Transmitter

This block sends one vector command, a 6-bit index with a 16-bit argument, to a remote receiver. A host drives the index and argument and pulses a one-cycle send strobe while the block is idle. The block latches both values and sends them on an asynchronous serial line as three bytes with no gap between them. It then holds the line high for a fixed trailing idle gap, so that a receiver that realigns on line idle time is ready for the next command. Busy covers the whole sequence, and a one-cycle done pulse marks its end.

The same latched index and argument also drive a parallel side channel. It raises a request level for a fixed number of clock cycles, so that a receiver which samples the request through a multi-stage synchronizer can take the command without the serial path. The clock frequency, bit rate, parity mode, idle gap length and request hold time are all build-time parameters.

Top module: `vec_cmd_tx`

## Requirements
- R1: While reset is asserted, and right after it is released, serOut is high and busy, done and parReq are low.
- R2: Each serial byte is a start bit (0), eight data bits sent LSB first, an optional parity bit and a stop bit (1). Every bit lasts BIT_CYC = CLK_HZ / BIT_HZ clock cycles, and the start bit of the first byte begins in the cycle after the strobe is taken.
- R3: A command is exactly three bytes sent back to back: first the index byte (index in bits 5..0, bits 7..6 zero), then argument bits 7..0, then argument bits 15..8.
- R4: When PARITY_EN is 1, a parity bit follows the data bits. With PARITY_ODD = 1 the data bits plus the parity bit hold an odd number of ones; with PARITY_ODD = 0 they hold an even number.
- R5: busy rises in the cycle after an accepted strobe. It stays high through the three bytes and the trailing gap, which is (3 x frame bits + IDLE_BITS) x BIT_CYC cycles in all.
- R6: done is high for exactly one cycle, in the first cycle in which busy is low again after a command.
- R7: A send strobe that arrives while busy is high is ignored. The serial bits, parIndex, parData and the completion time of the command in flight do not change.
- R8: parReq is high for exactly REQ_HOLD cycles, starting in the cycle after the strobe is taken. parIndex and parData show the latched index and argument from that cycle on.
- R9: serOut stays high for the whole trailing gap and while the block is idle. A new strobe is accepted in the cycle in which done is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sendStb | input | 1 | One-cycle request to send a command |
| cmdIndex | input | 6 | Vector index to send |
| cmdArg | input | 16 | Vector argument to send |
| busy | output | 1 | A command is in flight, including the trailing gap |
| done | output | 1 | One-cycle pulse when a command has finished |
| serOut | output | 1 | Serial line, idles high |
| parReq | output | 1 | Request level for the parallel side channel |
| parIndex | output | 6 | Latched index for the parallel side channel |
| parData | output | 16 | Latched argument for the parallel side channel |

## Verification
Commands are taken from a table. It holds all-zero and all-one words, alternating bit patterns, a single set bit in each argument byte, and values whose data bits hold an even or an odd number of ones. These separate a swapped byte order, a reversed bit order and a wrong parity sense. Every bit is sampled at its first cycle, at its middle and at its last cycle, so a bit period that is off by one cycle is caught. Further tests send a command in the very cycle done is high, send a strobe with other values partway through a command, and apply reset in the middle of a frame.

// File: rtl/vct_pkg.sv
`timescale 1ns/1ps
package vct_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_GAP  = 2'd2
  } vctState_t;

  typedef struct packed {
    logic       loadCmd;   // latch host values and load index byte frame
    logic       loadByte;  // load frame of latched byte byteSel
    logic       shiftBit;  // advance serial frame by one bit
    logic [1:0] byteSel;   // which byte loadByte picks
  } vctStrobe_t;

endpackage

// File: rtl/vct_datapath.sv
`timescale 1ns/1ps
module vct_datapath
  import vct_pkg::*;
#(
  parameter bit PARITY_EN  = 1'b1,
  parameter bit PARITY_ODD = 1'b1,
  localparam int FRAME_BITS = PARITY_EN ? 11 : 10
) (
  input  logic        clk,
  input  logic        rstN,
  input  vctStrobe_t  ctrl,
  input  logic [5:0]  cmdIndex,
  input  logic [15:0] cmdArg,
  output logic        serOut,
  output logic [5:0]  latIndex,
  output logic [15:0] latArg
);

  logic [7:0]            byteSrc;
  logic [FRAME_BITS-1:0] frameNext;
  logic [FRAME_BITS-1:0] frameQ;

  always_comb begin
    if (ctrl.loadCmd) begin
      byteSrc = {2'b00, cmdIndex};
    end else begin
      unique case (ctrl.byteSel)
        2'd0:    byteSrc = {2'b00, latIndex};
        2'd1:    byteSrc = latArg[7:0];
        default: byteSrc = latArg[15:8];
      endcase
    end
  end

  generate
    if (PARITY_EN) begin : g_par
      logic parBit;
      assign parBit    = (^byteSrc) ^ PARITY_ODD;
      assign frameNext = {1'b1, parBit, byteSrc, 1'b0};
    end else begin : g_nopar
      assign frameNext = {1'b1, byteSrc, 1'b0};
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latIndex <= '0;
      latArg   <= '0;
    end else if (ctrl.loadCmd) begin
      latIndex <= cmdIndex;
      latArg   <= cmdArg;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameQ <= '1;
    end else if (ctrl.loadCmd || ctrl.loadByte) begin
      frameQ <= frameNext;
    end else if (ctrl.shiftBit) begin
      frameQ <= {1'b1, frameQ[FRAME_BITS-1:1]};
    end
  end

  assign serOut = frameQ[0];

  AST_LOAD_GIVES_START: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.loadCmd || ctrl.loadByte) |=> !serOut) else $error("start bit missing"); // R2

endmodule

// File: rtl/vct_control.sv
`timescale 1ns/1ps
module vct_control
  import vct_pkg::*;
#(
  parameter int BIT_CYC    = 10,
  parameter int FRAME_BITS = 11,
  parameter int IDLE_BITS  = 16,
  parameter int REQ_HOLD   = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sendStb,
  output vctStrobe_t ctrl,
  output logic       busy,
  output logic       done,
  output logic       parReq
);

  localparam int BAUD_W = (BIT_CYC > 2) ? $clog2(BIT_CYC) : 1;
  localparam int BIT_W  = $clog2(FRAME_BITS);
  localparam int GAP_W  = (IDLE_BITS > 2) ? $clog2(IDLE_BITS) : 1;
  localparam int REQ_W  = $clog2(REQ_HOLD + 1);
  localparam logic [BAUD_W-1:0] BAUD_LAST = BAUD_W'(BIT_CYC - 1);
  localparam logic [BIT_W-1:0]  BIT_LAST  = BIT_W'(FRAME_BITS - 1);
  localparam logic [GAP_W-1:0]  GAP_LAST  = GAP_W'(IDLE_BITS - 1);

  vctState_t         state;
  logic [BAUD_W-1:0] baudCnt;
  logic [BIT_W-1:0]  bitCnt;
  logic [1:0]        byteCnt;
  logic [GAP_W-1:0]  gapCnt;
  logic [REQ_W-1:0]  reqCnt;
  logic              baudEnd;
  logic              frameEnd;
  logic              gapEnd;

  assign baudEnd  = (baudCnt == '0);
  assign frameEnd = baudEnd && (bitCnt == BIT_LAST);
  assign gapEnd   = (state == ST_GAP) && baudEnd && (gapCnt == '0);

  always_comb begin
    ctrl = '0;
    unique case (state)
      ST_IDLE: ctrl.loadCmd = sendStb;
      ST_SEND: begin
        if (frameEnd && byteCnt != 2'd2) begin
          ctrl.loadByte = 1'b1;
          ctrl.byteSel  = byteCnt + 2'd1;
        end else if (baudEnd) begin
          ctrl.shiftBit = 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      baudCnt <= '0;
      bitCnt  <= '0;
      byteCnt <= '0;
      gapCnt  <= '0;
      done    <= 1'b0;
    end else begin
      done <= gapEnd;
      unique case (state)
        ST_IDLE: begin
          if (sendStb) begin
            state   <= ST_SEND;
            baudCnt <= BAUD_LAST;
            bitCnt  <= '0;
            byteCnt <= '0;
          end
        end
        ST_SEND: begin
          if (!baudEnd) begin
            baudCnt <= baudCnt - 1'b1;
          end else begin
            baudCnt <= BAUD_LAST;
            if (bitCnt != BIT_LAST) begin
              bitCnt <= bitCnt + 1'b1;
            end else if (byteCnt == 2'd2) begin
              state  <= ST_GAP;
              gapCnt <= GAP_LAST;
            end else begin
              bitCnt  <= '0;
              byteCnt <= byteCnt + 2'd1;
            end
          end
        end
        ST_GAP: begin
          if (!baudEnd) begin
            baudCnt <= baudCnt - 1'b1;
          end else if (gapCnt == '0) begin
            state <= ST_IDLE;
          end else begin
            gapCnt  <= gapCnt - 1'b1;
            baudCnt <= BAUD_LAST;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqCnt <= '0;
    end else if (ctrl.loadCmd) begin
      reqCnt <= REQ_W'(REQ_HOLD);
    end else if (reqCnt != '0) begin
      reqCnt <= reqCnt - 1'b1;
    end
  end

  assign busy   = (state != ST_IDLE);
  assign parReq = (reqCnt != '0);

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done) else $error("done longer than one cycle"); // R6
  AST_DONE_AFTER_GAP: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ($past(state) == ST_GAP) && !busy) else $error("done without gap end"); // R6
  AST_BYTE_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SEND) |-> (byteCnt <= 2'd2)) else $error("more than three bytes"); // R3
  AST_REQ_WITHIN_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    parReq |-> busy) else $error("request outside command"); // R8
  AST_BUSY_HOLDS_STB: assert property (@(posedge clk) disable iff (!rstN)
    (busy && sendStb && !gapEnd) |=> busy) else $error("strobe disturbed busy"); // R7

endmodule

// File: rtl/vec_cmd_tx.sv
`timescale 1ns/1ps
module vec_cmd_tx
  import vct_pkg::*;
#(
  parameter int CLK_HZ     = 40_000_000,
  parameter int BIT_HZ     = 4_000_000,
  parameter bit PARITY_EN  = 1'b1,
  parameter bit PARITY_ODD = 1'b1,
  parameter int IDLE_BITS  = 16,
  parameter int REQ_HOLD   = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sendStb,
  input  logic [5:0]  cmdIndex,
  input  logic [15:0] cmdArg,
  output logic        busy,
  output logic        done,
  output logic        serOut,
  output logic        parReq,
  output logic [5:0]  parIndex,
  output logic [15:0] parData
);

  localparam int BIT_CYC    = CLK_HZ / BIT_HZ;
  localparam int FRAME_BITS = PARITY_EN ? 11 : 10;

  vctStrobe_t ctrl;

  vct_control #(
    .BIT_CYC    (BIT_CYC),
    .FRAME_BITS (FRAME_BITS),
    .IDLE_BITS  (IDLE_BITS),
    .REQ_HOLD   (REQ_HOLD)
  ) i_control (
    .clk     (clk),
    .rstN    (rstN),
    .sendStb (sendStb),
    .ctrl    (ctrl),
    .busy    (busy),
    .done    (done),
    .parReq  (parReq)
  );

  vct_datapath #(
    .PARITY_EN  (PARITY_EN),
    .PARITY_ODD (PARITY_ODD)
  ) i_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .cmdIndex (cmdIndex),
    .cmdArg   (cmdArg),
    .serOut   (serOut),
    .latIndex (parIndex),
    .latArg   (parData)
  );

  AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> serOut) else $error("line low while idle"); // R9
  AST_START_ON_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> !serOut) else $error("no start bit at busy rise"); // R2
  AST_LATCH_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> ($stable(parIndex) && $stable(parData)))
    else $error("latched values changed in flight"); // R7

endmodule

// File: tb/test_vec_cmd_tx.sv
`timescale 1ns/1ps
module test_vec_cmd_tx;

  localparam int CLK_PERIOD = 10;
  localparam int BITP       = 10;
  localparam int FB         = 11;
  localparam int IDLE       = 16;
  localparam int HOLD       = 4;
  localparam int TOT        = (3 * FB + IDLE) * BITP;
  localparam int NVEC       = 8;
  localparam logic [21:0] VEC [NVEC] = '{
    {6'h00, 16'h0000}, {6'h3F, 16'hFFFF}, {6'h15, 16'hA55A}, {6'h2A, 16'h0180},
    {6'h01, 16'h8001}, {6'h20, 16'h7E03}, {6'h07, 16'h00FF}, {6'h33, 16'hC3F0}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sendStb = 1'b0;
  logic [5:0]  cmdIndex = '0;
  logic [15:0] cmdArg = '0;
  logic        busy, done, serOut, parReq;
  logic [5:0]  parIndex;
  logic [15:0] parData;
  int          nChecks = 0;
  int          nFails = 0;
  bit          finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  vec_cmd_tx #(
    .CLK_HZ(40_000_000), .BIT_HZ(4_000_000), .PARITY_EN(1'b1),
    .PARITY_ODD(1'b1), .IDLE_BITS(IDLE), .REQ_HOLD(HOLD)
  ) i_vec_cmd_tx (
    .clk(clk), .rstN(rstN), .sendStb(sendStb), .cmdIndex(cmdIndex),
    .cmdArg(cmdArg), .busy(busy), .done(done), .serOut(serOut),
    .parReq(parReq), .parIndex(parIndex), .parData(parData)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic wrapUp();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  function automatic logic expBit(input logic [5:0] idx, input logic [15:0] arg, input int k);
    logic [7:0] d;
    int b = k / FB;
    int p = k % FB;
    d = (b == 0) ? {2'b00, idx} : (b == 1) ? arg[7:0] : arg[15:8];
    if (p == 0) return 1'b0;
    if (p <= 8) return d[p-1];
    if (p == 9) return (^d) ^ 1'b1;
    return 1'b1;
  endfunction

  // Starts at a negedge, ends at the negedge where done is expected high.
  task automatic sendCheck(input logic [5:0] idx, input logic [15:0] arg, input bit poke);
    sendStb  = 1'b1;
    cmdIndex = idx;
    cmdArg   = arg;
    @(posedge clk);
    for (int n = 0; n <= TOT; n++) begin
      @(negedge clk);
      if (n == 0) begin
        sendStb = 1'b0;
        cmdIndex = ~idx;
        cmdArg = ~arg;
        chk("R5 busy rise", busy, 1);
        chk("R6 done low", done, 0);
        chk("R8 parIndex", parIndex, idx);
        chk("R8 parData", parData, arg);
      end
      if (n < HOLD) chk("R8 parReq high", parReq, 1);
      if (n == HOLD) chk("R8 parReq low", parReq, 0);
      if (poke && n == 50) begin
        sendStb = 1'b1;
        cmdIndex = idx ^ 6'h2D;
        cmdArg = arg ^ 16'h5AA5;
      end
      if (poke && n == 51) sendStb = 1'b0;
      if (n < 3 * FB * BITP) begin
        if (n % BITP == 0 || n % BITP == BITP / 2 || n % BITP == BITP - 1)
          chk((n / BITP) % FB == 9 ? "R4 parity" : "R2 R3 serial bit",
              serOut, expBit(idx, arg, n / BITP));
      end else if (n < TOT && n % BITP == BITP / 2) begin
        chk("R9 gap high", serOut, 1);
      end
      if (n == TOT - 1) begin
        chk("R5 busy to end", busy, 1);
        chk("R6 done not early", done, 0);
        if (poke) begin
          chk("R7 parIndex held", parIndex, idx);
          chk("R7 parData held", parData, arg);
        end
      end
      if (n == TOT) begin
        chk("R6 done pulse", done, 1);
        chk("R5 busy low", busy, 0);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 serOut", serOut, 1);
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 parReq", parReq, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 after release", {serOut, busy, done, parReq}, 4'b1000);
    for (int i = 0; i < NVEC; i++) begin
      sendCheck(VEC[i][21:16], VEC[i][15:0], i == 3 || i == 6);
    end
    @(negedge clk);
    chk("R6 done one cycle", done, 0);
    repeat (30) @(negedge clk);
    chk("R9 idle line", serOut, 1);
    chk("R9 idle busy", busy, 0);
    sendStb = 1'b1;
    cmdIndex = 6'h2B;
    cmdArg = 16'h1234;
    @(posedge clk);
    @(negedge clk);
    sendStb = 1'b0;
    repeat (100) @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    chk("R1 mid-frame reset", {serOut, busy, done, parReq}, 4'b1000);
    rstN = 1'b1;
    @(negedge clk);
    sendCheck(6'h19, 16'h0F0F, 1'b0);
    @(negedge clk);
    wrapUp();
  end

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    wrapUp();
  end

endmodule